// File: doc/BRIEF.md
# Floating-Point Format Converter

This block converts a value from one numeric format to another: 32-bit two's-complement integers, single-precision floats and double-precision floats. A request is a one-cycle `start` pulse carrying an opcode, a 64-bit operand and a 2-bit rounding mode. The block captures all three on that edge. A fixed number of cycles later it raises `done` for one cycle. At that point it presents the converted value and four IEEE exception flags, and it holds both until the next conversion completes.

The converter handles integer to float, float to integer, and widening and narrowing between the two float widths. Subnormal operands and results are flushed to a zero of the same sign. Float-to-integer always truncates toward zero. Each direction raises only its own fixed subset of exceptions.

Top module: `fcvt_top`

## Requirements
- R1: A `start` sampled while idle is accepted, and the operand, opcode and rounding mode are captured on that edge. `done` is high for exactly one cycle, LATENCY rising edges after the accepting edge (default 4, at most 8). `result` and `flags` are valid with `done` and stay unchanged until the next `done`. A `start` that arrives while a conversion is in progress is ignored.
- R2: Opcode encoding: 0 integer→single, 1 integer→double, 2 single→integer, 3 double→integer, 4 single→double, 5 double→single. Opcodes 6 and 7 return zero with no flags. Any 32-bit source or destination uses bits [31:0], and bits [63:32] of a 32-bit result are zero. `flags` bit 3 is invalid, bit 2 overflow, bit 1 underflow and bit 0 inexact.
- R3: Integer→single rounds by `roundMode`, encoded 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward −infinity. Inexact is the only flag it can raise.
- R4: Integer→double is always exact and raises no flag.
- R5: Float→integer truncates toward zero whatever `roundMode` holds. It sets inexact when fraction bits are discarded, and it never raises overflow or underflow.
- R6: Float→integer raises invalid for a NaN, an infinity or a truncated value outside the 32-bit range. In that case it returns 0x7FFFFFFF for positive or NaN inputs and 0x80000000 for negative inputs. An input of exactly −2^31, or any value that truncates to −2^31, converts without invalid.
- R7: Single→double is exact. Its only possible flag is invalid, raised for a signaling NaN (quiet bit, fraction MSB, clear). A NaN leaves as a quiet NaN with the quiet bit set and the upper payload bits kept.
- R8: Double→single rounds the fraction by `roundMode` and sets inexact when any dropped bit is nonzero. NaNs are quieted as in R7 and raise invalid only when signaling.
- R9: A double→single result whose exponent exceeds the single range, before or after rounding, raises overflow and inexact. It returns infinity under nearest, under +infinity for positive values and under −infinity for negative values. Otherwise it returns the largest finite single of that sign.
- R10: A double→single result below the smallest normal single raises underflow and inexact and returns a zero of the operand's sign. Subnormal operands of any conversion are treated as a signed zero and raise no flag.
- R11: While reset is held, `done`, `result` and `flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe, accepted only while idle |
| opcode | input | 3 | Conversion selector (encoding in R2) |
| operand | input | 64 | Source value |
| roundMode | input | 2 | Rounding mode (encoding in R3) |
| result | output | 64 | Converted value, held until next completion |
| flags | output | 4 | {invalid, overflow, underflow, inexact} |
| done | output | 1 | One-cycle completion strobe |

## Verification
Every result, and its flags, is due at exactly the LATENCY-th rising edge after the edge that accepts `start`, and `done` must be low at every edge before that. The bench drives inputs on falling edges and checks `done` at each falling edge between acceptance and completion. It then reads `result` and `flags` at the falling edge that follows the due edge. Right after acceptance it scrambles the operand and rounding mode, so a design that did not capture them on the accepting edge gives wrong values. A second `start` issued mid-conversion must neither change the result nor produce a further `done` in the following LATENCY+2 cycles.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

  localparam logic [2:0] OP_I2S = 3'd0;
  localparam logic [2:0] OP_I2D = 3'd1;
  localparam logic [2:0] OP_S2I = 3'd2;
  localparam logic [2:0] OP_D2I = 3'd3;
  localparam logic [2:0] OP_S2D = 3'd4;
  localparam logic [2:0] OP_D2S = 3'd5;

  localparam logic [1:0] RM_NEAR = 2'd0;
  localparam logic [1:0] RM_ZERO = 2'd1;
  localparam logic [1:0] RM_POS  = 2'd2;
  localparam logic [1:0] RM_NEG  = 2'd3;

  localparam int FLG_INV = 3;
  localparam int FLG_OVF = 2;
  localparam int FLG_UNF = 1;
  localparam int FLG_NX  = 0;

  typedef struct packed {
    logic load;
    logic capture;
  } fcvtStrobe_t;

  // Decide whether the truncated magnitude must be incremented.
  function automatic logic roundUp(input logic sign, input logic lsb,
                                   input logic guard, input logic sticky,
                                   input logic [1:0] rm);
    logic up;
    case (rm)
      RM_NEAR: up = guard & (sticky | lsb);
      RM_POS:  up = ~sign & (guard | sticky);
      RM_NEG:  up = sign & (guard | sticky);
      default: up = 1'b0;
    endcase
    return up;
  endfunction

  // Count of leading zeros; input zero is handled by the caller.
  function automatic logic [4:0] lzc32(input logic [31:0] v);
    logic [4:0] n;
    n = 5'd0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) n = 5'(31 - i);
    end
    return n;
  endfunction

  // Saturated single-precision result on overflow.
  function automatic logic [31:0] ovfSingle(input logic sign, input logic [1:0] rm);
    logic toInf;
    toInf = (rm == RM_NEAR) || (rm == RM_POS && !sign) || (rm == RM_NEG && sign);
    return {sign, toInf ? 31'h7F800000 : 31'h7F7FFFFF};
  endfunction

endpackage

// File: rtl/fcvt_ctrl.sv
module fcvt_ctrl
  import fcvt_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output fcvtStrobe_t strb,
  output logic        done
);

  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  typedef enum logic {S_IDLE, S_BUSY} ctrlState_t;

  ctrlState_t state;
  logic [CW-1:0] cnt;

  always_comb begin
    strb.load    = (state == S_IDLE) && start;
    strb.capture = (state == S_BUSY) && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= strb.capture;
      case (state)
        S_IDLE: begin
          if (start) begin
            state <= S_BUSY;
            cnt   <= CW'(LAT - 1);
          end
        end
        default: begin
          if (cnt == '0) state <= S_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/fcvt_dpath.sv
module fcvt_dpath
  import fcvt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  fcvtStrobe_t strb,
  input  logic [2:0]  opIn,
  input  logic [63:0] operandIn,
  input  logic [1:0]  rmIn,
  output logic [63:0] result,
  output logic [3:0]  flags
);

  logic [2:0]  opQ;
  logic [63:0] aQ;
  logic [1:0]  rmQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ <= '0;
      aQ  <= '0;
      rmQ <= '0;
    end else if (strb.load) begin
      opQ <= opIn;
      aQ  <= operandIn;
      rmQ <= rmIn;
    end
  end

  // Common unpack of a single or double source
  logic srcSingle, uSign, uNan, uInf, uZero;
  logic signed [12:0] uExp;
  logic [51:0] uFrac;

  always_comb begin
    srcSingle = (opQ == OP_S2I) || (opQ == OP_S2D);
    if (srcSingle) begin
      uSign = aQ[31];
      uFrac = {aQ[22:0], 29'b0};
      uNan  = (&aQ[30:23]) && (|aQ[22:0]);
      uInf  = (&aQ[30:23]) && !(|aQ[22:0]);
      uZero = !(|aQ[30:23]);
      uExp  = $signed({5'b0, aQ[30:23]}) - 13'sd127;
    end else begin
      uSign = aQ[63];
      uFrac = aQ[51:0];
      uNan  = (&aQ[62:52]) && (|aQ[51:0]);
      uInf  = (&aQ[62:52]) && !(|aQ[51:0]);
      uZero = !(|aQ[62:52]);
      uExp  = $signed({2'b0, aQ[62:52]}) - 13'sd1023;
    end
  end

  // Float to integer, truncating
  logic [63:0] sigW, lostMask;
  logic [5:0]  shAmt;
  logic [31:0] ipW, f2iRes;
  logic        f2iInv, f2iNx;

  always_comb begin
    sigW     = {11'b0, 1'b1, uFrac};
    shAmt    = 6'(13'sd52 - uExp);
    ipW      = 32'(sigW >> shAmt);
    lostMask = (64'd1 << shAmt) - 64'd1;
    f2iRes   = '0;
    f2iInv   = 1'b0;
    f2iNx    = 1'b0;
    if (uNan) begin
      f2iInv = 1'b1;
      f2iRes = 32'h7FFFFFFF;
    end else if (uInf) begin
      f2iInv = 1'b1;
      f2iRes = uSign ? 32'h80000000 : 32'h7FFFFFFF;
    end else if (uZero) begin
      f2iRes = '0;
    end else if (uExp < 13'sd0) begin
      f2iNx = 1'b1;
    end else if (uExp > 13'sd30) begin
      if (uSign && uExp == 13'sd31 && uFrac[51:21] == '0) begin
        f2iRes = 32'h80000000;
        f2iNx  = |uFrac[20:0];
      end else begin
        f2iInv = 1'b1;
        f2iRes = uSign ? 32'h80000000 : 32'h7FFFFFFF;
      end
    end else begin
      f2iRes = uSign ? (~ipW + 32'd1) : ipW;
      f2iNx  = |(sigW & lostMask);
    end
  end

  // Integer to float
  logic [31:0] iMag;
  logic [4:0]  iLz;
  logic [30:0] iFrac, i2sPre, i2sSum;
  logic        i2sRnd, iZero;

  always_comb begin
    iMag   = aQ[31] ? (~aQ[31:0] + 32'd1) : aQ[31:0];
    iZero  = (aQ[31:0] == '0);
    iLz    = lzc32(iMag);
    iFrac  = 31'(iMag << iLz);
    i2sPre = {8'd158 - {3'b0, iLz}, iFrac[30:8]};
    i2sRnd = roundUp(aQ[31], iFrac[8], iFrac[7], |iFrac[6:0], rmQ);
    i2sSum = i2sPre + {30'b0, i2sRnd};
  end

  // Double to single narrowing
  logic signed [12:0] dBiased;
  logic [30:0] d2sPre, d2sSum;
  logic        d2sRnd;

  always_comb begin
    dBiased = $signed({2'b0, aQ[62:52]}) - 13'sd896;
    d2sPre  = {dBiased[7:0], aQ[51:29]};
    d2sRnd  = roundUp(aQ[63], aQ[29], aQ[28], |aQ[27:0], rmQ);
    d2sSum  = d2sPre + {30'b0, d2sRnd};
  end

  logic [63:0] resNext;
  logic [3:0]  flgNext;

  always_comb begin
    resNext = '0;
    flgNext = '0;
    case (opQ)
      OP_I2S: begin
        resNext = iZero ? 64'd0 : {32'b0, aQ[31], i2sSum};
        flgNext[FLG_NX] = !iZero && (iFrac[7] || (|iFrac[6:0]));
      end
      OP_I2D: begin
        resNext = iZero ? 64'd0 :
                  {aQ[31], 11'd1054 - {6'b0, iLz}, iFrac, 21'b0};
      end
      OP_S2I, OP_D2I: begin
        resNext = {32'b0, f2iRes};
        flgNext[FLG_INV] = f2iInv;
        flgNext[FLG_NX]  = f2iNx;
      end
      OP_S2D: begin
        if (uNan) begin
          resNext = {uSign, 11'h7FF, 1'b1, aQ[21:0], 29'b0};
          flgNext[FLG_INV] = !aQ[22];
        end else if (uInf) begin
          resNext = {uSign, 11'h7FF, 52'b0};
        end else if (uZero) begin
          resNext = {uSign, 63'b0};
        end else begin
          resNext = {uSign, {3'b0, aQ[30:23]} + 11'd896, aQ[22:0], 29'b0};
        end
      end
      OP_D2S: begin
        if (uNan) begin
          resNext = {32'b0, uSign, 8'hFF, 1'b1, aQ[50:29]};
          flgNext[FLG_INV] = !aQ[51];
        end else if (uInf) begin
          resNext = {32'b0, uSign, 8'hFF, 23'b0};
        end else if (uZero) begin
          resNext = {32'b0, uSign, 31'b0};
        end else if (dBiased <= 13'sd0) begin
          resNext = {32'b0, uSign, 31'b0};
          flgNext[FLG_UNF] = 1'b1;
          flgNext[FLG_NX]  = 1'b1;
        end else if (dBiased >= 13'sd255 || d2sSum[30:23] == 8'hFF) begin
          resNext = {32'b0, ovfSingle(uSign, rmQ)};
          flgNext[FLG_OVF] = 1'b1;
          flgNext[FLG_NX]  = 1'b1;
        end else begin
          resNext = {32'b0, uSign, d2sSum};
          flgNext[FLG_NX] = aQ[28] || (|aQ[27:0]);
        end
      end
      default: begin
        resNext = '0;
        flgNext = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      flags  <= '0;
    end else if (strb.capture) begin
      result <= resNext;
      flags  <= flgNext;
    end
  end

endmodule

// File: rtl/fcvt_top.sv
module fcvt_top
  import fcvt_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  opcode,
  input  logic [63:0] operand,
  input  logic [1:0]  roundMode,
  output logic [63:0] result,
  output logic [3:0]  flags,
  output logic        done
);

  fcvtStrobe_t strb;

  fcvt_ctrl #(.LAT(LATENCY)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .done  (done)
  );

  fcvt_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opIn      (opcode),
    .operandIn (operand),
    .rmIn      (roundMode),
    .result    (result),
    .flags     (flags)
  );

endmodule

// File: rtl/fcvt_checker.sv
module fcvt_checker
  import fcvt_pkg::*;
#(
  parameter int LAT = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [2:0]  opcode,
  input logic [63:0] result,
  input logic [3:0]  flags,
  input logic        done
);

  localparam int MW = $clog2(LAT + 1) + 1;

  logic          busyM, doneM;
  logic [MW-1:0] cntM;
  logic [2:0]    opM;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyM <= 1'b0;
      doneM <= 1'b0;
      cntM  <= '0;
      opM   <= '0;
    end else begin
      doneM <= busyM && (cntM == MW'(LAT));
      if (!busyM) begin
        if (start) begin
          busyM <= 1'b1;
          cntM  <= MW'(1);
          opM   <= opcode;
        end
      end else if (cntM == MW'(LAT)) begin
        busyM <= 1'b0;
      end else begin
        cntM <= cntM + 1'b1;
      end
    end
  end

  logic isF2i;
  assign isF2i = (opM == OP_S2I) || (opM == OP_D2I);

  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    done == doneM);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(result) && $stable(flags)));

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (done && opM != OP_I2D && opM != OP_S2D) |-> result[63:32] == 32'd0);

  p_i2s_flags_r3: assert property (@(posedge clk) disable iff (!rstN)
    (done && opM == OP_I2S) |-> flags[3:1] == 3'b000);

  p_i2d_exact_r4: assert property (@(posedge clk) disable iff (!rstN)
    (done && opM == OP_I2D) |-> flags == 4'b0000);

  p_f2i_no_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && isF2i) |-> (!flags[FLG_OVF] && !flags[FLG_UNF]));

  p_f2i_sat_r6: assert property (@(posedge clk) disable iff (!rstN)
    (done && isF2i && flags[FLG_INV]) |->
      (result[31:0] == 32'h7FFFFFFF || result[31:0] == 32'h80000000));

  p_s2d_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && opM == OP_S2D) |-> flags[2:0] == 3'b000);

  p_ovf_nx_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && flags[FLG_OVF]) |-> flags[FLG_NX]);

  p_unf_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done && flags[FLG_UNF]) |-> (result[30:0] == 31'd0 && flags[FLG_NX]));

endmodule

bind fcvt_top fcvt_checker #(.LAT(LATENCY)) u_fcvt_checker (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .opcode  (opcode),
  .result  (result),
  .flags   (flags),
  .done    (done)
);

// File: tb/fcvt_top_bench.sv
`timescale 1ns/1ps
module fcvt_top_bench;
  import fcvt_pkg::*;

  localparam int LAT = 4;
  localparam logic [3:0] F_NONE = 4'b0000;
  localparam logic [3:0] F_INV  = 4'b1000;
  localparam logic [3:0] F_OVF  = 4'b0100;
  localparam logic [3:0] F_UNF  = 4'b0010;
  localparam logic [3:0] F_NX   = 4'b0001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opcode = '0;
  logic [63:0] operand = '0;
  logic [1:0]  roundMode = '0;
  logic [63:0] result;
  logic [3:0]  flags;
  logic        done;

  int totalCnt = 0;
  int passCnt = 0;

  always #2.5 clk = ~clk;

  fcvt_top #(.LATENCY(LAT)) u_fcvt_top (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .opcode    (opcode),
    .operand   (operand),
    .roundMode (roundMode),
    .result    (result),
    .flags     (flags),
    .done      (done)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    totalCnt++;
    if (act === exp) passCnt++;
    else $display("FAIL %s: actual %h expected %h", tag, act, exp);
  endtask

  // R1: start at one falling edge, done due after the LAT-th following rising edge
  task automatic runOp(input logic [2:0] op, input logic [63:0] a, input logic [1:0] rm,
                       input string tag, input logic [63:0] expR, input logic [3:0] expF);
    logic early;
    early = 1'b0;
    @(negedge clk);
    opcode = op; operand = a; roundMode = rm; start = 1'b1;
    @(negedge clk);
    start = 1'b0; operand = ~a; roundMode = ~rm;
    for (int k = 0; k < LAT; k++) begin
      if (done) early = 1'b1;
      @(negedge clk);
    end
    chk({tag, " R1 timing"}, {63'b0, done & ~early}, 64'd1);
    chk({tag, " result"}, result, expR);
    chk({tag, " flags"}, {60'b0, flags}, {60'b0, expF});
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R11 reset result", result, 64'd0);
    chk("R11 reset flags", {60'b0, flags}, 64'd0);
    chk("R11 reset done", {63'b0, done}, 64'd0);
  endtask

  task automatic testIntToSingle();
    runOp(OP_I2S, 64'h1, RM_NEAR, "R3 i2s one", 64'h3F800000, F_NONE);
    runOp(OP_I2S, 64'hFFFFFFFF, RM_NEAR, "R3 i2s minus one", 64'hBF800000, F_NONE);
    runOp(OP_I2S, 64'h0, RM_POS, "R3 i2s zero", 64'h0, F_NONE);
    runOp(OP_I2S, 64'h7FFFFFFF, RM_NEAR, "R3 i2s max nearest", 64'h4F000000, F_NX);
    runOp(OP_I2S, 64'h7FFFFFFF, RM_ZERO, "R3 i2s max tozero", 64'h4EFFFFFF, F_NX);
    runOp(OP_I2S, 64'h01000001, RM_NEAR, "R3 i2s tie even", 64'h4B800000, F_NX);
    runOp(OP_I2S, 64'h01000001, RM_POS, "R3 i2s tie posinf", 64'h4B800001, F_NX);
    runOp(OP_I2S, 64'h80000000, RM_NEAR, "R3 i2s min int", 64'hCF000000, F_NONE);
  endtask

  task automatic testIntToDouble();
    runOp(OP_I2D, 64'h1, RM_NEAR, "R4 i2d one", 64'h3FF0000000000000, F_NONE);
    runOp(OP_I2D, 64'hFFFFFFFB, RM_POS, "R4 i2d minus five", 64'hC014000000000000, F_NONE);
    runOp(OP_I2D, 64'h7FFFFFFF, RM_ZERO, "R4 i2d max", 64'h41DFFFFFFFC00000, F_NONE);
  endtask

  task automatic testFloatToInt();
    runOp(OP_S2I, 64'h40200000, RM_NEAR, "R5 s2i 2.5 nearest", 64'h2, F_NX);
    runOp(OP_S2I, 64'h40200000, RM_POS, "R5 s2i 2.5 posinf", 64'h2, F_NX);
    runOp(OP_S2I, 64'hC0200000, RM_NEG, "R5 s2i -2.5 neginf", 64'hFFFFFFFE, F_NX);
    runOp(OP_S2I, 64'h3F000000, RM_NEAR, "R5 s2i half", 64'h0, F_NX);
    runOp(OP_S2I, 64'h42C80000, RM_NEAR, "R5 s2i hundred", 64'h64, F_NONE);
    runOp(OP_D2I, 64'hC00E000000000000, RM_POS, "R5 d2i -3.75", 64'hFFFFFFFD, F_NX);
    runOp(OP_D2I, 64'h41DFFFFFFFC00000, RM_NEAR, "R5 d2i max", 64'h7FFFFFFF, F_NONE);
    runOp(OP_S2I, 64'h4F000000, RM_NEAR, "R6 s2i 2^31", 64'h7FFFFFFF, F_INV);
    runOp(OP_S2I, 64'hCF000000, RM_NEAR, "R6 s2i -2^31", 64'h80000000, F_NONE);
    runOp(OP_S2I, 64'h7FC00000, RM_NEAR, "R6 s2i nan", 64'h7FFFFFFF, F_INV);
    runOp(OP_S2I, 64'hFF800000, RM_NEAR, "R6 s2i -inf", 64'h80000000, F_INV);
    runOp(OP_D2I, 64'h41E0000000000000, RM_NEAR, "R6 d2i 2^31", 64'h7FFFFFFF, F_INV);
    runOp(OP_D2I, 64'hC1E0000000100000, RM_NEAR, "R6 d2i -2^31-half", 64'h80000000, F_NX);
  endtask

  task automatic testWiden();
    runOp(OP_S2D, 64'h3F800000, RM_NEAR, "R7 s2d one", 64'h3FF0000000000000, F_NONE);
    runOp(OP_S2D, 64'h7F800001, RM_NEAR, "R7 s2d snan", 64'h7FF8000020000000, F_INV);
    runOp(OP_S2D, 64'hFFC00000, RM_NEAR, "R7 s2d qnan", 64'hFFF8000000000000, F_NONE);
    runOp(OP_S2D, 64'hFF800000, RM_NEAR, "R7 s2d -inf", 64'hFFF0000000000000, F_NONE);
    runOp(OP_S2D, 64'h80000001, RM_NEAR, "R10 s2d subnormal", 64'h8000000000000000, F_NONE);
  endtask

  task automatic testNarrowRound();
    runOp(OP_D2S, 64'h3FF0000000000000, RM_NEAR, "R8 d2s one", 64'h3F800000, F_NONE);
    runOp(OP_D2S, 64'h3FF0000010000000, RM_NEAR, "R8 d2s tie even", 64'h3F800000, F_NX);
    runOp(OP_D2S, 64'h3FF0000010000000, RM_POS, "R8 d2s tie posinf", 64'h3F800001, F_NX);
    runOp(OP_D2S, 64'h3FF0000010000000, RM_ZERO, "R8 d2s tie tozero", 64'h3F800000, F_NX);
    runOp(OP_D2S, 64'h3FF0000030000000, RM_NEAR, "R8 d2s tie odd", 64'h3F800002, F_NX);
    runOp(OP_D2S, 64'hBFF0000010000000, RM_NEG, "R8 d2s neg neginf", 64'hBF800001, F_NX);
    runOp(OP_D2S, 64'h7FF0000000000001, RM_NEAR, "R8 d2s snan", 64'h7FC00000, F_INV);
    runOp(OP_D2S, 64'h7FFC000000000000, RM_NEAR, "R8 d2s qnan payload", 64'h7FE00000, F_NONE);
    runOp(OP_D2S, 64'h7FF0000000000000, RM_NEAR, "R8 d2s inf", 64'h7F800000, F_NONE);
  endtask

  task automatic testNarrowRange();
    runOp(OP_D2S, 64'h7FE0000000000000, RM_NEAR, "R9 ovf nearest", 64'h7F800000, F_OVF | F_NX);
    runOp(OP_D2S, 64'h7FE0000000000000, RM_ZERO, "R9 ovf tozero", 64'h7F7FFFFF, F_OVF | F_NX);
    runOp(OP_D2S, 64'hFFE0000000000000, RM_POS, "R9 ovf neg posinf", 64'hFF7FFFFF, F_OVF | F_NX);
    runOp(OP_D2S, 64'hFFE0000000000000, RM_NEG, "R9 ovf neg neginf", 64'hFF800000, F_OVF | F_NX);
    runOp(OP_D2S, 64'h47EFFFFFF0000000, RM_NEAR, "R9 round into ovf", 64'h7F800000, F_OVF | F_NX);
    runOp(OP_D2S, 64'h47EFFFFFF0000000, RM_ZERO, "R9 max finite", 64'h7F7FFFFF, F_NX);
    runOp(OP_D2S, 64'h3800000000000000, RM_NEAR, "R10 unf pos", 64'h00000000, F_UNF | F_NX);
    runOp(OP_D2S, 64'hB800000000000000, RM_NEAR, "R10 unf neg", 64'h80000000, F_UNF | F_NX);
    runOp(OP_D2S, 64'h3810000000000000, RM_NEAR, "R10 min normal", 64'h00800000, F_NONE);
    runOp(OP_D2S, 64'h0000000000000001, RM_POS, "R10 subnormal in", 64'h00000000, F_NONE);
  endtask

  task automatic testReserved();
    runOp(3'd6, 64'h3FF0000000000000, RM_NEAR, "R2 reserved 6", 64'h0, F_NONE);
    runOp(3'd7, 64'hFFFFFFFFFFFFFFFF, RM_NEG, "R2 reserved 7", 64'h0, F_NONE);
  endtask

  // R1: a second start during a conversion is ignored
  task automatic testBusyIgnore();
    int extra;
    @(negedge clk);
    opcode = OP_I2D; operand = 64'h1; roundMode = RM_NEAR; start = 1'b1;
    @(negedge clk);
    opcode = OP_I2S; operand = 64'hFFFFFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k < LAT; k++) @(negedge clk);
    chk("R1 busy done", {63'b0, done}, 64'd1);
    chk("R1 busy result", result, 64'h3FF0000000000000);
    extra = 0;
    for (int k = 0; k < LAT + 2; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R1 busy no second done", 64'(extra), 64'd0);
    chk("R1 busy result held", result, 64'h3FF0000000000000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testIntToSingle();
    testIntToDouble();
    testFloatToInt();
    testWiden();
    testNarrowRound();
    testNarrowRange();
    testReserved();
    testBusyIgnore();
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    totalCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

endmodule